// File: doc/BRIEF.md
# Microsecond System Timer with Compare Channels

This block keeps a free-running time base for a chip and raises per-channel interrupts at scheduled times. A counter split into a low word and a high word advances by one on every clock cycle in which the `tick` strobe is high. In normal use `tick` pulses once per microsecond, so the counter measures elapsed microseconds. The high word advances when the low word wraps to zero.

Each compare channel holds a target value for the low word. When the low word reaches that value, the channel's flag latches and the channel's interrupt output goes high. The flag stays set until the host writes a one to the matching bit of the status register. To schedule a periodic event, the host reads the low word, adds the period and writes the sum back to the compare register. The register bus is a plain single-cycle port. A write takes effect on the clock edge, and read data is combinational from the address.

Top module: `sys_timer`

## Requirements
- R1: After reset, the low word, the high word, every compare register and every flag read as zero, and `irq` is all zero.
- R2: The low word (byte offset 0x04) increases by exactly one on each clock edge where `tick` is high. It holds its value on every other edge.
- R3: On a tick where the low word is all ones, the low word wraps to zero and the high word (offset 0x08) increases by one. The high word changes at no other time.
- R4: Status register bit i (offset 0x00) is the flag of channel i. The flag sets on the tick edge where the low word takes the value held in compare register i, including a target reached through the wrap, and `irq[i]` always equals that flag.
- R5: A set flag stays set across further ticks until the host clears it.
- R6: A write to offset 0x00 with data bit i at 1 clears flag i. Data bits at 0 leave their flags unchanged.
- R7: If channel i matches on the same edge as a write that clears flag i, the flag ends set.
- R8: Compare register i sits at byte offset 0x0C + 4*i. It can be written at any time and reads back the value written.
- R9: Writes to offsets 0x04 and 0x08 leave both counter words unchanged.
- R10: A read from any offset outside the status, counter and compare registers, including an offset that is not word aligned, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per microsecond |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero-extended |
| irq | output | NUM_CH | Per-channel interrupt, equal to the channel flag |

## Verification
The bench builds the block with LO_W = 8, keeping four channels and a 32-bit high word. With this setting, a low-word wrap and the resulting high-word increment happen after a few hundred ticks, so R3 and a compare target reached only through the wrap can be checked directly. All other behaviour, including the same-edge set/clear collision and per-bit clearing, does not depend on the width, so the default 32-bit build behaves the same apart from the wrap period.

// File: rtl/sys_timer.sv
module sys_timer #(
  parameter int NUM_CH = 4,
  parameter int LO_W   = 32,
  parameter int HI_W   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int DW       = 32;
  localparam int OFF_STAT = 0;
  localparam int OFF_LO   = 4;
  localparam int OFF_HI   = 8;
  localparam int OFF_CMP  = 12;

  logic [LO_W-1:0]        cnt_lo;
  logic [HI_W-1:0]        cnt_hi;
  logic [NUM_CH*LO_W-1:0] cmp_flat;
  logic [NUM_CH-1:0]      flag;

  wire [LO_W-1:0] lo_next = cnt_lo + 1'b1;
  wire            lo_wrap = &cnt_lo;
  wire            stat_wr = bus_we && (bus_addr == ADDR_W'(OFF_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (tick) begin
      cnt_lo <= lo_next;
      if (lo_wrap) cnt_hi <= cnt_hi + 1'b1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    wire cmp_wr = bus_we && (bus_addr == ADDR_W'(OFF_CMP + 4*ch));
    wire hit    = tick && (lo_next == cmp_flat[ch*LO_W +: LO_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_flat[ch*LO_W +: LO_W] <= '0;
      else if (cmp_wr) cmp_flat[ch*LO_W +: LO_W] <= bus_wdata[LO_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        flag[ch] <= 1'b0;
      else if (hit)                      flag[ch] <= 1'b1;
      else if (stat_wr && bus_wdata[ch]) flag[ch] <= 1'b0;
    end
  end

  assign irq = flag;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = DW'(flag);
    if (bus_addr == ADDR_W'(OFF_LO))   bus_rdata = DW'(cnt_lo);
    if (bus_addr == ADDR_W'(OFF_HI))   bus_rdata = DW'(cnt_hi);
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr == ADDR_W'(OFF_CMP + 4*c)) bus_rdata = DW'(cmp_flat[c*LO_W +: LO_W]);
  end
endmodule

module sys_timer_chk #(
  parameter int NUM_CH = 4,
  parameter int LO_W   = 32,
  parameter int HI_W   = 32,
  parameter int ADDR_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_we,
  input logic [31:0]            bus_wdata,
  input logic [NUM_CH-1:0]      irq,
  input logic [LO_W-1:0]        cnt_lo,
  input logic [HI_W-1:0]        cnt_hi,
  input logic [NUM_CH*LO_W-1:0] cmp_flat
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  always @(posedge clk)
    if (!rst_n) assert_reset_clear_R1: assert (irq == '0 && cnt_lo == '0 && cnt_hi == '0);

  assert_lo_step_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(tick) |-> cnt_lo == LO_W'($past(cnt_lo) + 1'b1));
  assert_lo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(tick) |-> $stable(cnt_lo));
  assert_hi_step_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(tick && (&cnt_lo)) |-> cnt_hi == HI_W'($past(cnt_hi) + 1'b1));
  assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(tick && (&cnt_lo)) |-> $stable(cnt_hi));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $rose(irq[c]) |-> $past(tick) && cnt_lo == $past(cmp_flat[c*LO_W +: LO_W]));
    assert_match_sets_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(tick) && cnt_lo == $past(cmp_flat[c*LO_W +: LO_W])) |-> irq[c]);
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $fell(irq[c]) |-> $past(bus_we && bus_addr == '0 && bus_wdata[c]));
  end
endmodule

bind sys_timer sys_timer_chk #(.NUM_CH(NUM_CH), .LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq(irq), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cmp_flat(cmp_flat)
);

// File: tb/tb_sys_timer.sv
module tb_sys_timer;
  localparam int NUM_CH = 4;
  localparam int LO_W   = 8;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int failures = 0;
  int exp_lo = 0;
  int exp_hi = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sys_timer #(.NUM_CH(NUM_CH), .LO_W(LO_W), .HI_W(32), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      exp_lo = (exp_lo + 1) % 256;
      if (exp_lo == 0) exp_hi++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    for (int a = 0; a <= 'h18; a += 4) begin
      rd(ADDR_W'(a), v);
      chk("R1 register", v, 0);
    end
  endtask

  task automatic t_count();
    logic [31:0] v;
    repeat (10) @(negedge clk);
    rd(8'h04, v); chk("R2 idle hold", v, 0);
    ticks(10);
    rd(8'h04, v); chk("R2 ten ticks", v, 32'(exp_lo));
    rd(8'h08, v); chk("R3 high idle", v, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    wr(8'h04, 32'h77);
    wr(8'h08, 32'h55);
    rd(8'h04, v); chk("R9 low unchanged", v, 32'(exp_lo));
    rd(8'h08, v); chk("R9 high unchanged", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h1C, v); chk("R10 0x1C", v, 0);
    rd(8'h40, v); chk("R10 0x40", v, 0);
    rd(8'h05, v); chk("R10 misaligned", v, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(8'h18, 32'hA5);
    rd(8'h18, v); chk("R8 cmp3 readback", v, 32'hA5);
    wr(8'h10, 32'h3C);
    rd(8'h10, v); chk("R8 cmp1 readback", v, 32'h3C);
    wr(8'h10, 32'h00);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(8'h00, 32'hF);
    wr(8'h0C, 32'(exp_lo + 5));
    ticks(4);
    rd(8'h00, v); chk("R4 before target", v, 0);
    ticks(1);
    rd(8'h00, v); chk("R4 at target", v, 32'h1);
    chk("R4 irq follows flag", 32'(irq), 32'h1);
    ticks(3);
    rd(8'h00, v); chk("R5 sticky", v, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R6 zero write no effect", v, 32'h1);
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R6 one clears", v, 0);
    chk("R6 irq low", 32'(irq), 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(8'h10, 32'(exp_lo + 1));
    ticks(1);
    rd(8'h00, v); chk("R4 ch1 set", v[1], 1);
    wr(8'h10, 32'(exp_lo + 1));
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'h2; bus_we = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    exp_lo = (exp_lo + 1) % 256;
    rd(8'h00, v); chk("R7 set wins", v[1], 1);
    wr(8'h00, 32'h2);
    rd(8'h00, v); chk("R6 ch1 cleared", v[1], 0);
  endtask

  task automatic t_multi();
    logic [31:0] v;
    wr(8'h0C, 32'(exp_lo + 2));
    wr(8'h14, 32'(exp_lo + 4));
    wr(8'h00, 32'hF);
    ticks(2);
    rd(8'h00, v); chk("R4 ch0 only", v, 32'h1);
    ticks(2);
    rd(8'h00, v); chk("R4 ch0 and ch2", v, 32'h5);
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R6 per-bit clear", v, 32'h4);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(8'h14, 32'h01);
    wr(8'h00, 32'hF);
    ticks(255 - exp_lo);
    rd(8'h04, v); chk("R3 low at max", v, 32'hFF);
    rd(8'h08, v); chk("R3 high before wrap", v, 0);
    rd(8'h00, v); chk("R4 ch2 not yet", v[2], 0);
    ticks(1);
    rd(8'h04, v); chk("R3 low wrapped", v, 0);
    rd(8'h08, v); chk("R3 high incremented", v, 32'(exp_hi));
    ticks(1);
    rd(8'h00, v); chk("R4 match after wrap", v[2], 1);
    chk("R4 irq2", 32'(irq[2]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_ignore();
    t_unmapped();
    t_readback();
    t_match();
    t_clear();
    t_collide();
    t_multi();
    t_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule